// File: doc/BRIEF.md
# Selectable Bipolar Line Code Encoder

This block converts a transmit bit stream into the two pulse flags that drive a bipolar T1/E1/J1 line interface: one flag asks for a positive pulse, the other for a negative pulse, and neither means a space. The bit timing comes from a transmit clock `tclk` that is observed by the fast system clock `clk`. A configuration bit picks which `tclk` transition takes a bit. One bit is taken per `tclk` period, and the outputs are updated only at that moment.

In single-rail operation the bit on `din_p` is coded with one of three rules, picked by `code_sel`. The first is plain alternate mark inversion. The second is HDB3, which replaces runs of four zeros. The third is B8ZS, which replaces runs of eight zeros. Zero substitution has to rewrite bits that arrived earlier, so every coded bit passes through an eight-bit look-ahead line and emerges a fixed eight bit times later. In dual-rail operation the coder is bypassed: the two input rails already carry coded data and are mapped straight onto the pulse flags.

Top module: `line_coder`

## Requirements
- R1: `code_sel` 2'b00 and 2'b11 select AMI: each one bit becomes a pulse whose polarity is the opposite of the previous pulse, and each zero bit becomes a space.
- R2: `code_sel` 2'b01 selects HDB3. Each run of four zeros not already substituted becomes 000V when an odd number of pulses went out since the last V. Otherwise it becomes B00V. V repeats the polarity of the previous pulse, and B takes the opposite polarity.
- R3: `code_sel` 2'b10 selects B8ZS: each run of eight zeros becomes 000VB0VB, with V and B polarities as in R2.
- R4: In the coded modes, the bit taken at bit strobe k appears on the outputs after bit strobe k+8. After reset the first eight outputs are spaces, and the first pulse is positive.
- R5: With `edge_sel` 0 a bit is taken at the first `clk` rising edge at which `tclk` reads high after reading low. With `edge_sel` 1 it is taken where `tclk` first reads low after reading high. The opposite transition takes nothing.
- R6: In single-rail mode (`dual_rail` 0) the level of `din_n` has no effect on the outputs.
- R7: In dual-rail mode (`dual_rail` 1), at each bit strobe the outputs take the sampled rails. `din_p` high with `din_n` low gives a positive pulse, and `din_n` high with `din_p` low gives a negative pulse. Both low, or both high, gives a space.
- R8: `pulse_p` and `pulse_n` are never high together.
- R9: The outputs change only at a bit strobe or at reset.
- R10: A synchronous active-high `rst` forces both outputs low at the next `clk` edge and clears the polarity history and the look-ahead line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than `tclk` |
| rst | input | 1 | Synchronous reset, active high |
| tclk | input | 1 | Transmit bit clock, observed by `clk` |
| edge_sel | input | 1 | 0: take bits on `tclk` rising, 1: on `tclk` falling |
| code_sel | input | 2 | 00/11 AMI, 01 HDB3, 10 B8ZS |
| dual_rail | input | 1 | 1: bypass coder and map input rails directly |
| din_p | input | 1 | NRZ data (single rail) or positive rail (dual rail) |
| din_n | input | 1 | Negative rail (dual rail only) |
| pulse_p | output | 1 | Send a positive pulse for this bit |
| pulse_n | output | 1 | Send a negative pulse for this bit |

## Verification
A wrong polarity memory in the coder shows up at the first mark that follows the fault, eight bit strobes later, as a pulse of the wrong sign. The same sign error then repeats on every following mark until the next reset. A wrong zero-run count or a wrong HDB3 parity shows up as a misplaced or wrongly shaped substitution. That error surfaces the eight strobes later that the look-ahead line imposes, and its polarity error is then carried forward into the rest of the stream. A sampling-edge fault shows up within one bit, because the bench puts the complement of the data on the input around the unchosen transition.

// File: rtl/line_coder.sv
module line_coder (
  input  logic       clk,
  input  logic       rst,
  input  logic       tclk,
  input  logic       edge_sel,
  input  logic [1:0] code_sel,
  input  logic       dual_rail,
  input  logic       din_p,
  input  logic       din_n,
  output logic       pulse_p,
  output logic       pulse_n
);
  localparam int DEPTH = 8;
  localparam int RUN_W = $clog2(DEPTH) + 1;
  localparam logic [1:0] T_PLAIN = 2'd0;
  localparam logic [1:0] T_BAL   = 2'd1;
  localparam logic [1:0] T_VIOL  = 2'd2;

  logic tclk_q;
  logic strobe;
  logic [DEPTH-1:0] dat, dat_nx;
  logic [DEPTH-1:0][1:0] tag, tag_nx;
  logic [RUN_W-1:0] run, run_inc;
  logic par, last_pos;
  logic is_hdb3, is_b8zs, sub4, sub8;
  logic head_dat;
  logic [1:0] head_tag;
  logic emit_alt, emit_same, nx_p, nx_n;

  assign strobe  = edge_sel ? (tclk_q & ~tclk) : (~tclk_q & tclk);
  assign is_hdb3 = (code_sel == 2'b01);
  assign is_b8zs = (code_sel == 2'b10);
  assign run_inc = run + 1'b1;
  assign sub4    = is_hdb3 & ~din_p & (run_inc == RUN_W'(4));
  assign sub8    = is_b8zs & ~din_p & (run_inc == RUN_W'(8));

  assign head_dat  = dat[DEPTH-1];
  assign head_tag  = tag[DEPTH-1];
  assign emit_alt  = head_dat | (head_tag == T_BAL);
  assign emit_same = ~head_dat & (head_tag == T_VIOL);
  assign nx_p = (emit_alt & ~last_pos) | (emit_same & last_pos);
  assign nx_n = (emit_alt & last_pos) | (emit_same & ~last_pos);

  always_comb begin
    dat_nx = {dat[DEPTH-2:0], din_p};
    tag_nx = {tag[DEPTH-2:0], T_PLAIN};
    if (sub8) begin
      tag_nx[7] = T_PLAIN;
      tag_nx[6] = T_PLAIN;
      tag_nx[5] = T_PLAIN;
      tag_nx[4] = T_VIOL;
      tag_nx[3] = T_BAL;
      tag_nx[2] = T_PLAIN;
      tag_nx[1] = T_VIOL;
      tag_nx[0] = T_BAL;
    end
    if (sub4) begin
      tag_nx[3] = par ? T_PLAIN : T_BAL;
      tag_nx[2] = T_PLAIN;
      tag_nx[1] = T_PLAIN;
      tag_nx[0] = T_VIOL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tclk_q   <= 1'b0;
      dat      <= '0;
      tag      <= '0;
      run      <= '0;
      par      <= 1'b0;
      last_pos <= 1'b0;
      pulse_p  <= 1'b0;
      pulse_n  <= 1'b0;
    end else begin
      tclk_q <= tclk;
      if (strobe) begin
        if (dual_rail) begin
          pulse_p <= din_p & ~din_n;
          pulse_n <= din_n & ~din_p;
        end else begin
          dat     <= dat_nx;
          tag     <= tag_nx;
          run     <= (din_p | sub4 | sub8 | ~(is_hdb3 | is_b8zs)) ? '0 : run_inc;
          par     <= sub4 ? 1'b0 : (par ^ din_p);
          pulse_p <= nx_p;
          pulse_n <= nx_n;
          if (emit_alt) last_pos <= ~last_pos;
        end
      end
    end
  end
endmodule

module line_coder_chk (
  input logic clk,
  input logic rst,
  input logic strobe,
  input logic dual_rail,
  input logic din_p,
  input logic din_n,
  input logic pulse_p,
  input logic pulse_n
);
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pulse_p && pulse_n));

  a_r10_reset_space: assert property (@(posedge clk)
    rst |=> (!pulse_p && !pulse_n));

  a_r9_hold_between: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> ($stable(pulse_p) && $stable(pulse_n)));

  a_r7_dual_map: assert property (@(posedge clk) disable iff (rst)
    (strobe && dual_rail) |=> (pulse_p == $past(din_p && !din_n)) &&
                              (pulse_n == $past(din_n && !din_p)));
endmodule

bind line_coder line_coder_chk u_chk (
  .clk(clk), .rst(rst), .strobe(strobe), .dual_rail(dual_rail),
  .din_p(din_p), .din_n(din_n), .pulse_p(pulse_p), .pulse_n(pulse_n)
);

// File: tb/tb_line_coder.sv
module tb_line_coder;
  localparam int CLK_P = 10;
  localparam int NB    = 2100;
  localparam int LAT   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tclk = 1'b0;
  logic edge_sel = 1'b0;
  logic [1:0] code_sel = 2'b00;
  logic dual_rail = 1'b0;
  logic din_p = 1'b0;
  logic din_n = 1'b0;
  logic pulse_p, pulse_n;

  int n_cmp = 0;
  int n_bad = 0;
  int prev_act = 0;
  bit stream [NB];
  int exp_code [NB];

  line_coder dut (
    .clk(clk), .rst(rst), .tclk(tclk), .edge_sel(edge_sel),
    .code_sel(code_sel), .dual_rail(dual_rail), .din_p(din_p),
    .din_n(din_n), .pulse_p(pulse_p), .pulse_n(pulse_n)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int out_code();
    return (pulse_p && pulse_n) ? 3 : pulse_p ? 1 : pulse_n ? 2 : 0;
  endfunction

  function automatic int pol(int s);
    return (s > 0) ? 1 : 2;
  endfunction

  task automatic check(string req, string what, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic void build_ref(int mode);
    int lastp = -1;
    int marks = 0;
    int i = 0;
    while (i < NB) begin
      bit z8 = (i + 8 <= NB);
      bit z4 = (i + 4 <= NB);
      for (int j = 0; j < 8; j++) if (i + j < NB && stream[i+j]) begin
        z8 = 0;
        if (j < 4) z4 = 0;
      end
      if (stream[i]) begin
        lastp = -lastp; exp_code[i] = pol(lastp); marks++; i++;
      end else if (mode == 2 && z8) begin
        exp_code[i] = 0; exp_code[i+1] = 0; exp_code[i+2] = 0;
        exp_code[i+3] = pol(lastp);
        lastp = -lastp; exp_code[i+4] = pol(lastp);
        exp_code[i+5] = 0;
        exp_code[i+6] = pol(lastp);
        lastp = -lastp; exp_code[i+7] = pol(lastp);
        i += 8;
      end else if (mode == 1 && z4) begin
        if (marks % 2 == 1) begin
          exp_code[i] = 0; exp_code[i+1] = 0; exp_code[i+2] = 0;
          exp_code[i+3] = pol(lastp);
        end else begin
          lastp = -lastp; exp_code[i] = pol(lastp);
          exp_code[i+1] = 0; exp_code[i+2] = 0;
          exp_code[i+3] = pol(lastp);
        end
        marks = 0; i += 4;
      end else begin
        exp_code[i] = 0; i++;
      end
    end
  endfunction

  task automatic do_reset(bit es);
    @(negedge clk);
    rst = 1'b1; tclk = es;
    repeat (3) @(negedge clk);
    check("R10", "reset output", out_code(), 0);
    rst = 1'b0;
    prev_act = 0;
  endtask

  // One bit period: the unchosen edge sees complemented data, the chosen edge sees the bit.
  task automatic drive_bit(bit p, bit n, bit es, bit dual, string req);
    @(negedge clk);
    tclk = es; din_p = ~p; din_n = dual ? ~n : 1'($urandom);
    @(negedge clk);
    check({req, "/R9"}, "hold before strobe", out_code(), prev_act);
    din_p = p; din_n = dual ? n : 1'($urandom);
    @(negedge clk);
    tclk = ~es;
    @(negedge clk);
    if (!dual) din_n = 1'($urandom);
    prev_act = out_code();
    check("R8", "rails exclusive", int'(prev_act == 3), 0);
  endtask

  task automatic run_coded(int mode, bit es);
    string req;
    req = (mode == 1) ? "R2" : (mode == 2) ? "R3" : "R1";
    code_sel = 2'(mode); edge_sel = es; dual_rail = 1'b0;
    build_ref((mode == 3) ? 0 : mode);
    do_reset(es);
    for (int k = 0; k < NB; k++) begin
      drive_bit(stream[k], 1'b0, es, 1'b0, req);
      if (k < LAT) check("R4", "leading space", prev_act, 0);
      else check({req, "/R4/R5/R6"}, $sformatf("bit %0d", k - LAT), prev_act, exp_code[k-LAT]);
    end
  endtask

  task automatic run_dual(bit es);
    code_sel = 2'b01; edge_sel = es; dual_rail = 1'b1;
    do_reset(es);
    for (int i = 0; i < 64; i++) begin
      int pr = (i * 3 + i / 4) % 4;
      bit p = pr[1];
      bit n = pr[0];
      drive_bit(p, n, es, 1'b1, "R7");
      check("R7/R5", $sformatf("rails p=%0d n=%0d", p, n), prev_act,
            (p && !n) ? 1 : (n && !p) ? 2 : 0);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < NB; k++) begin
      int b = k / 8;
      stream[k] = (k < 2048) ? b[7 - (k % 8)] : (k >= 2092);
    end
    run_coded(0, 1'b0);
    run_coded(1, 1'b1);
    run_coded(2, 1'b0);
    run_coded(3, 1'b1);
    run_coded(1, 1'b0);
    run_coded(2, 1'b1);
    run_dual(1'b0);
    run_dual(1'b1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule